// File: doc/BRIEF.md
# Decode-Stage Hazard Resolver with Registered Bypass Selects

This unit sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it takes the two source register numbers of the instruction in decode and compares them with the destinations that older instructions hold in the EX and MEM pipeline registers. Each comparison is qualified by that stage's write enable. From these comparisons it decides, for each operand, where the EX stage should take the value from on the next cycle. It can also find that the value cannot be supplied yet, which happens when a load sits directly ahead of a dependent instruction. In that case it raises a stall.

The bypass selects are worked out in decode and registered at the same clock edge that moves the instruction into EX. The EX-stage operand muxes therefore receive a select that was settled one cycle earlier. Seen from EX, the producer that was in EX at decode time is now in MEM, so its value is taken from the EX/MEM ALU result. A producer that was in MEM at decode time is now in WB, so its value is taken from the MEM/WB result.

A producer already in WB needs no path. The register file writes in the first half of the cycle and reads in the second. When a stall is raised, the pipeline freezes the PC and the IF/ID register and clears the write and memory-write controls entering ID/EX.

Top module: `hazard_bypass_unit`

## Requirements
- R1: With no qualified match on any used operand, stall_o and bubble_o stay 0, and after the next rising clock edge both selects read 2'b00 (register file).
- R2: If a used source equals the EX destination, EX write enable is 1, the EX instruction is not a load, and the register is nonzero, then that operand's select reads 2'b01 (EX/MEM ALU result) after the next clock edge.
- R3: If a used source equals the MEM destination, MEM write enable is 1, and there is no qualifying EX match, then that operand's select reads 2'b10 (MEM/WB result) after the next clock edge.
- R4: If the EX and MEM stages both hold a qualified write to the same source register, the nearer EX producer wins and the select is 2'b01.
- R5: A source or destination of register 0 never causes forwarding or a stall.
- R6: When an operand's use flag is 0, its source field is ignored. Its select is 2'b00 and it cannot cause a stall.
- R7: If a used source matches a qualified EX destination whose instruction is a load, stall_o and bubble_o are both 1 in that same cycle (combinational).
- R8: In a stall cycle, both selects registered at the next edge are 2'b00, even when the other operand would forward. The stall overrides all forwarding.
- R9: A stage whose write enable is 0 never produces a match, whatever its destination field holds.
- R10: Asserting rst_ni low clears both selects to 2'b00 at once (asynchronous reset).
- R11: A load sitting in MEM that matches a used source is forwarded with select 2'b10 and causes no stall.
- R12: The two operands are resolved independently. Operand A (id_rs_i) drives fwd_a_o, and operand B (id_rt_i) drives fwd_b_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pipeline clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_rs_i | input | REG_AW | Decode source register A |
| id_rt_i | input | REG_AW | Decode source register B |
| id_use_rs_i | input | 1 | Instruction reads source A |
| id_use_rt_i | input | 1 | Instruction reads source B |
| ex_rd_i | input | REG_AW | Destination held in ID/EX |
| ex_we_i | input | 1 | Register write enable held in ID/EX |
| ex_load_i | input | 1 | Instruction in EX is a load |
| mem_rd_i | input | REG_AW | Destination held in EX/MEM |
| mem_we_i | input | 1 | Register write enable held in EX/MEM |
| stall_o | output | 1 | Freeze PC and IF/ID this cycle |
| bubble_o | output | 1 | Clear write and memory-write controls entering ID/EX |
| fwd_a_o | output | 2 | Registered EX-stage select for operand A |
| fwd_b_o | output | 2 | Registered EX-stage select for operand B |

## Verification
A faulty comparator or a wrong priority order shows up exactly one edge after the decode inputs are applied, as a wrong select code on fwd_a_o or fwd_b_o. A missed load-use case shows up at once, in the same cycle, as stall_o and bubble_o staying low. The bench checks stall_o and bubble_o combinationally in the middle of the cycle and checks the selects just after the following edge. Because the unit holds only the two select registers, a bad value cannot persist: the next decode overwrites it.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              use_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  output logic              hit_ex_o,
  output logic              hit_mem_o
);
  logic live;
  // register 0 is hardwired, unused fields never compare
  assign live      = use_i && (src_i != '0);
  assign hit_ex_o  = live && ex_we_i  && (src_i == ex_rd_i);
  assign hit_mem_o = live && mem_we_i && (src_i == mem_rd_i);
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
(
  input  logic     hit_ex_i,
  input  logic     hit_mem_i,
  input  logic     ex_load_i,
  output fwd_sel_e sel_o,
  output logic     load_use_o
);
  assign load_use_o = hit_ex_i && ex_load_i;

  always_comb begin
    if (hit_ex_i)       sel_o = ex_load_i ? FWD_RF : FWD_EXMEM;
    else if (hit_mem_i) sel_o = FWD_MEMWB;
    else                sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg
  import hz_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     kill_i,
  input  fwd_sel_e sel_i,
  output fwd_sel_e sel_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q_o <= FWD_RF;
    else if (kill_i) sel_q_o <= FWD_RF;
    else             sel_q_o <= sel_i;
  end
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic              id_use_rs_i,
  input  logic              id_use_rt_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  output logic              stall_o,
  output logic              bubble_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o
);
  localparam int NOPS = 2;

  logic [REG_AW-1:0] src   [NOPS];
  logic [NOPS-1:0]   use_v;
  logic [NOPS-1:0]   hit_ex, hit_mem, load_use;
  fwd_sel_e          sel_d [NOPS];
  fwd_sel_e          sel_q [NOPS];
  logic              stall;

  assign src[0]   = id_rs_i;
  assign src[1]   = id_rt_i;
  assign use_v[0] = id_use_rs_i;
  assign use_v[1] = id_use_rt_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_match #(.REG_AW(REG_AW)) u_match (
      .src_i    (src[g]),
      .use_i    (use_v[g]),
      .ex_rd_i  (ex_rd_i),
      .ex_we_i  (ex_we_i),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .hit_ex_o (hit_ex[g]),
      .hit_mem_o(hit_mem[g])
    );
    hz_operand_sel u_sel (
      .hit_ex_i  (hit_ex[g]),
      .hit_mem_i (hit_mem[g]),
      .ex_load_i (ex_load_i),
      .sel_o     (sel_d[g]),
      .load_use_o(load_use[g])
    );
    // a stall turns the slot entering EX into a bubble: no forwarding
    hz_sel_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .kill_i (stall),
      .sel_i  (sel_d[g]),
      .sel_q_o(sel_q[g])
    );
  end

  assign stall    = |load_use;
  assign stall_o  = stall;
  assign bubble_o = stall;
  assign fwd_a_o  = sel_q[0];
  assign fwd_b_o  = sel_q[1];
endmodule

// File: rtl/hazard_bypass_unit_chk.sv
module hazard_bypass_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] id_rs_i,
  input logic [REG_AW-1:0] id_rt_i,
  input logic              id_use_rs_i,
  input logic              id_use_rt_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              ex_we_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_rd_i,
  input logic              mem_we_i,
  input logic              stall_o,
  input logic              bubble_o,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o
);
  AST_STALL_KILLS_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)); // R8
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_load_i && ex_we_i && bubble_o)); // R7
  AST_ZERO_DEST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0 && mem_rd_i == '0) |-> !stall_o ##1 (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)); // R5
  AST_NO_ILLEGAL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)); // R2
  AST_UNUSED_A_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_use_rs_i |=> (fwd_a_o == 2'b00)); // R6
  AST_UNUSED_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_use_rt_i |=> (fwd_b_o == 2'b00)); // R6
  AST_NO_WE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_we_i && !mem_we_i) |-> !stall_o ##1 (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)); // R9
endmodule

bind hazard_bypass_unit hazard_bypass_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .id_rs_i(id_rs_i), .id_rt_i(id_rt_i),
  .id_use_rs_i(id_use_rs_i), .id_use_rt_i(id_use_rt_i), .ex_rd_i(ex_rd_i),
  .ex_we_i(ex_we_i), .ex_load_i(ex_load_i), .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i),
  .stall_o(stall_o), .bubble_o(bubble_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o)
);

// File: tb/tb_hazard_bypass_unit.sv
module tb_hazard_bypass_unit;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] id_rs_i = '0, id_rt_i = '0, ex_rd_i = '0, mem_rd_i = '0;
  logic          id_use_rs_i = 1'b0, id_use_rt_i = 1'b0;
  logic          ex_we_i = 1'b0, ex_load_i = 1'b0, mem_we_i = 1'b0;
  logic          stall_o, bubble_o;
  logic [1:0]    fwd_a_o, fwd_b_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  hazard_bypass_unit #(.REG_AW(AW)) dut (.*);

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // expected select for one operand, plus load-use flag
  function automatic logic [2:0] ref_op(input logic [AW-1:0] s, input logic u);
    if (!u || s == '0) return 3'b000;
    if (ex_we_i && ex_rd_i == s) return ex_load_i ? 3'b100 : 3'b001;
    if (mem_we_i && mem_rd_i == s) return 3'b010;
    return 3'b000;
  endfunction

  task automatic run(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                     input logic urs, input logic urt,
                     input logic [AW-1:0] erd, input logic ewe, input logic eld,
                     input logic [AW-1:0] mrd, input logic mwe, input string tag);
    logic [2:0] ea, eb;
    logic       st;
    @(negedge clk_i);
    id_rs_i = rs; id_rt_i = rt; id_use_rs_i = urs; id_use_rt_i = urt;
    ex_rd_i = erd; ex_we_i = ewe; ex_load_i = eld; mem_rd_i = mrd; mem_we_i = mwe;
    #1;
    ea = ref_op(rs, urs);
    eb = ref_op(rt, urt);
    st = ea[2] | eb[2];
    chk({tag, " stall"},  {1'b0, stall_o},  {1'b0, st});
    chk({tag, " bubble"}, {1'b0, bubble_o}, {1'b0, st});
    @(posedge clk_i);
    #1;
    chk({tag, " fwd_a"}, fwd_a_o, st ? 2'b00 : ea[1:0]);
    chk({tag, " fwd_b"}, fwd_b_o, st ? 2'b00 : eb[1:0]);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk("R10 reset fwd_a", fwd_a_o, 2'b00);
    chk("R10 reset fwd_b", fwd_b_o, 2'b00);
    @(negedge clk_i) rst_ni = 1'b1;

    run(5'd1, 5'd2, 1, 1, 5'd3, 1, 0, 5'd4, 1, "R1 no match");
    run(5'd7, 5'd2, 1, 1, 5'd7, 1, 0, 5'd4, 1, "R2 ex fwd A");
    run(5'd1, 5'd9, 1, 1, 5'd3, 1, 0, 5'd9, 1, "R3 mem fwd B");
    run(5'd6, 5'd6, 1, 1, 5'd6, 1, 0, 5'd6, 1, "R4 nearest wins");
    run(5'd0, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0, 1, "R5 reg zero");
    run(5'd8, 5'd8, 0, 0, 5'd8, 1, 1, 5'd8, 1, "R6 unused ops");
    run(5'd3, 5'd3, 1, 0, 5'd3, 1, 0, 5'd0, 0, "R6 rt unused");
    run(5'd4, 5'd5, 1, 1, 5'd5, 1, 1, 5'd0, 0, "R7 load use B");
    run(5'd4, 5'd5, 1, 1, 5'd4, 1, 1, 5'd5, 1, "R8 stall overrides");
    run(5'd4, 5'd5, 1, 1, 5'd4, 0, 1, 5'd5, 0, "R9 we low");
    run(5'd12, 5'd1, 1, 1, 5'd3, 1, 0, 5'd12, 1, "R11 load in mem");
    run(5'd10, 5'd11, 1, 1, 5'd10, 1, 0, 5'd11, 1, "R12 independent");

    // R10: asynchronous clear while a forward is held
    run(5'd7, 5'd7, 1, 1, 5'd7, 1, 0, 5'd0, 0, "R2 prep");
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    chk("R10 async fwd_a", fwd_a_o, 2'b00);
    chk("R10 async fwd_b", fwd_b_o, 2'b00);
    @(negedge clk_i) rst_ni = 1'b1;

    // R12 random: narrow register range to force collisions
    for (int i = 0; i < 400; i++) begin
      run(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
          1'($urandom), 1'($urandom),
          AW'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
          AW'($urandom_range(0, 3)), 1'($urandom), "R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule